// File: doc/BRIEF.md
# Dual-Source Interrupt Flag Controller

The block merges two interrupt sources onto one active-high CPU request line. The main group has five active-low inputs: one external interrupt pin and four port pins. In edge mode, any falling edge in this group sets the main pending flag. In level mode, the flag is set while any input of the group is low. A separate active-low port pin has its own pending flag, which a falling edge sets. Each flag has an enable bit, and the request output is raised when an enabled flag is pending.

Software reaches the block through one 8-bit control/status register:

| Bit | Name | Behaviour |
|-----|------|-----------|
| 0 | main enable | read/write |
| 1 | aux enable | read/write |
| 2 | main acknowledge | write-one; reads as 0 |
| 3 | aux acknowledge | write-one; reads as 0 |
| 4 | main flag | read-only |
| 5 | aux flag | read-only |

A vector-fetch strobe from the CPU clears the main flag automatically, but only while the aux enable is clear. Whenever the aux source is enabled, software must acknowledge the main flag explicitly. The aux flag is never cleared by a vector fetch.

Top module: `irq_flag_ctrl`

## Requirements
- R1: While reset is asserted, the register reads 0x00 and irq_o is low. This covers both flags and both enables.
- R2: Every pin input passes through a two-flop synchronizer before detection. A pin change applied before clock edge k shows in the flag after edge k+2, and not earlier.
- R3: In edge mode, a falling edge on any of the five main inputs sets the main flag (bit 4). Keeping an input low after the flag has been acknowledged does not set the flag again.
- R4: Writing to bit 4 or bit 5 has no effect on either flag.
- R5: A vector-fetch strobe clears the main flag when the aux enable (bit 1) is clear.
- R6: A vector-fetch strobe leaves the main flag set when the aux enable is set. A vector-fetch strobe never clears the aux flag.
- R7: Writing 1 to bit 2 clears the main flag, whatever value the aux enable holds.
- R8: A falling edge on the aux pin sets the aux flag (bit 5). The aux flag is cleared only by writing 1 to bit 3.
- R9: irq_o is high exactly when (main flag AND main enable) OR (aux flag AND aux enable). A flag whose enable is clear does not raise irq_o.
- R10: In level mode, the main flag is set in every cycle in which any synchronized main input is low. As a result, an acknowledge has no lasting effect while a source stays low.
- R11: When a set event and an acknowledge for the same flag fall in the same cycle, the flag ends up set.
- R12: The enable bits change only on a register write or on reset. Bits 2 and 3 always read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| level_mode_i | input | 1 | Static mode select: 1 = level-sensitive main group, 0 = falling-edge |
| main_pins_ni | input | 5 | Active-low main group inputs: bit 4 = external pin, bits 3:0 = port pins |
| aux_pin_ni | input | 1 | Active-low aux port pin |
| vec_fetch_i | input | 1 | One-cycle strobe when the CPU fetches the interrupt vector |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write data |
| rd_data_o | output | 8 | Register read value |
| irq_o | output | 1 | Interrupt request to the CPU, active high |

## Verification
The main group is driven in three ways: a single falling edge on a port pin, a falling edge on the external pin, and a held-low input in each mode. The held-low case is what separates level behaviour (the flag comes back after an acknowledge) from edge behaviour (the flag stays clear). Vector fetches are issued with the aux enable both clear and set, which shows the conditional auto-clear. An acknowledge is placed in the exact cycle of a set event to show which one wins. The aux pin is exercised with its enable off and then on, so that a pending flag can be told apart from a raised request.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;
  localparam int REG_W       = 8;
  localparam int NUM_MAIN    = 5;
  localparam int B_MAIN_EN   = 0;
  localparam int B_AUX_EN    = 1;
  localparam int B_MAIN_ACK  = 2;
  localparam int B_AUX_ACK   = 3;
  localparam int B_MAIN_FLAG = 4;
  localparam int B_AUX_FLAG  = 5;

  typedef struct packed {
    logic aux_en;
    logic main_en;
  } irq_en_t;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  // idle-high pins: reset to 1 so no false edge after reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '1;
      s2_q <= '1;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/fall_det.sv
module fall_det #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '1;
    else         prev_q <= lvl_i;
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign fall_o[i] = prev_q[i] & ~lvl_i[i];
  end
endmodule

// File: rtl/pend_flag.sv
module pend_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;
    else if (clr_i)  flag_o <= 1'b0;
  end
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
  import irq_flag_pkg::*;
#(
  parameter int N_MAIN = NUM_MAIN
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              level_mode_i,
  input  logic [N_MAIN-1:0] main_pins_ni,
  input  logic              aux_pin_ni,
  input  logic              vec_fetch_i,
  input  logic              wr_en_i,
  input  logic [REG_W-1:0]  wr_data_i,
  output logic [REG_W-1:0]  rd_data_o,
  output logic              irq_o
);
  localparam int NP = N_MAIN + 1;

  logic [NP-1:0] pins_sync, pins_fall;
  logic          main_set, main_clr, aux_set, aux_clr;
  logic          main_flag, aux_flag;
  irq_en_t       en_q;
  logic          unused_wr_bits;

  pin_sync #(.W(NP)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({aux_pin_ni, main_pins_ni}),
    .q_o   (pins_sync)
  );

  fall_det #(.W(NP)) u_fall (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (pins_sync),
    .fall_o(pins_fall)
  );

  assign main_set = level_mode_i ? ~&pins_sync[N_MAIN-1:0]
                                 : |pins_fall[N_MAIN-1:0];
  assign aux_set  = pins_fall[N_MAIN];

  // auto-clear on vector fetch is blocked while aux source enabled
  assign main_clr = (wr_en_i & wr_data_i[B_MAIN_ACK]) | (vec_fetch_i & ~en_q.aux_en);
  assign aux_clr  = wr_en_i & wr_data_i[B_AUX_ACK];

  pend_flag u_main_flag (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (main_set),
    .clr_i (main_clr),
    .flag_o(main_flag)
  );

  pend_flag u_aux_flag (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (aux_set),
    .clr_i (aux_clr),
    .flag_o(aux_flag)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= '0;
    end else if (wr_en_i) begin
      en_q.main_en <= wr_data_i[B_MAIN_EN];
      en_q.aux_en  <= wr_data_i[B_AUX_EN];
    end
  end

  assign unused_wr_bits = ^{wr_data_i[REG_W-1:B_MAIN_FLAG]};

  always_comb begin
    rd_data_o              = '0;
    rd_data_o[B_MAIN_EN]   = en_q.main_en;
    rd_data_o[B_AUX_EN]    = en_q.aux_en;
    rd_data_o[B_MAIN_FLAG] = main_flag;
    rd_data_o[B_AUX_FLAG]  = aux_flag;
  end

  assign irq_o = (main_flag & en_q.main_en) | (aux_flag & en_q.aux_en);
endmodule

// File: rtl/irq_flag_ctrl_chk.sv
module irq_flag_ctrl_chk
  import irq_flag_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             vec_fetch_i,
  input logic             wr_en_i,
  input logic [REG_W-1:0] wr_data_i,
  input logic [REG_W-1:0] rd_data_o,
  input logic             irq_o
);
  a_r8_aux_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o[B_AUX_FLAG] && !(wr_en_i && wr_data_i[B_AUX_ACK])) |=> rd_data_o[B_AUX_FLAG]);

  a_r6_vec_keeps_main: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o[B_MAIN_FLAG] && rd_data_o[B_AUX_EN] && vec_fetch_i &&
     !(wr_en_i && wr_data_i[B_MAIN_ACK])) |=> rd_data_o[B_MAIN_FLAG]);

  a_r9_irq_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((rd_data_o[B_MAIN_FLAG] && rd_data_o[B_MAIN_EN]) ||
               (rd_data_o[B_AUX_FLAG] && rd_data_o[B_AUX_EN])));

  a_r12_en_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(rd_data_o[B_AUX_EN:B_MAIN_EN]));
endmodule

bind irq_flag_ctrl irq_flag_ctrl_chk u_chk (.*);

// File: tb/sim_irq_flag_ctrl.sv
module sim_irq_flag_ctrl;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       level_mode = 1'b0;
  logic [4:0] main_pins = 5'h1f;
  logic       aux_pin = 1'b1;
  logic       vec = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       irq;

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R1";
  bit    done = 0;

  always #4 clk = ~clk;

  irq_flag_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_ni), .level_mode_i(level_mode),
    .main_pins_ni(main_pins), .aux_pin_ni(aux_pin), .vec_fetch_i(vec),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_data_o(rd_data), .irq_o(irq)
  );

  // behavioural reference: pin history kept in a queue, newest first
  logic [5:0] hist[$] = '{6'h3f, 6'h3f, 6'h3f};
  bit m_mf = 0, m_af = 0, m_me = 0, m_ae = 0;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      hist = '{6'h3f, 6'h3f, 6'h3f};
      m_mf = 0; m_af = 0; m_me = 0; m_ae = 0;
    end else begin
      bit mset, aset, mclr, aclr;
      logic [5:0] cur, old;
      cur  = hist[1];
      old  = hist[2];
      mset = level_mode ? (cur[4:0] != 5'h1f) : ((old[4:0] & ~cur[4:0]) != 0);
      aset = old[5] && !cur[5];
      mclr = (wr_en && wr_data[2]) || (vec && !m_ae);
      aclr = wr_en && wr_data[3];
      if (mset) m_mf = 1; else if (mclr) m_mf = 0;
      if (aset) m_af = 1; else if (aclr) m_af = 0;
      if (wr_en) begin m_me = wr_data[0]; m_ae = wr_data[1]; end
      hist.push_front({aux_pin, main_pins});
      void'(hist.pop_back());
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_ni && !done) begin
      chk({cur_req, " model rd"}, rd_data, {2'b00, m_af, m_mf, 2'b00, m_ae, m_me});
      chk({cur_req, " model irq"}, irq, (m_mf && m_me) || (m_af && m_ae));
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    tick(1);
    wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic fetch();
    vec = 1'b1;
    tick(1);
    vec = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    tick(2);
    chk("R1 reset reg", rd_data, 8'h00);
    chk("R1 reset irq", irq, 0);
    rst_ni = 1'b1;
    tick(1);

    cur_req = "R12";
    wr(8'h03);
    chk("R12 enables set", rd_data[1:0], 2'b11);
    chk("R12 ack bits read zero", rd_data[3:2], 2'b00);

    cur_req = "R2";
    main_pins[3] = 1'b0;
    tick(2);
    chk("R2 not before third edge", rd_data[4], 0);
    tick(1);
    chk("R2 flag after third edge", rd_data[4], 1);
    chk("R9 irq from main", irq, 1);
    main_pins[3] = 1'b1;
    tick(3);

    cur_req = "R4";
    wr(8'h33);
    chk("R4 flag bits unaffected", rd_data[5:4], 2'b01);

    cur_req = "R6";
    fetch();
    chk("R6 vec keeps main with aux_en", rd_data[4], 1);

    cur_req = "R7";
    wr(8'h07);
    chk("R7 main ack clears", rd_data[4], 0);
    chk("R7 irq low", irq, 0);

    cur_req = "R5";
    wr(8'h01);
    main_pins[4] = 1'b0;
    tick(3);
    chk("R3 ext pin edge sets", rd_data[4], 1);
    main_pins[4] = 1'b1;
    fetch();
    chk("R5 vec clears main", rd_data[4], 0);
    tick(3);

    cur_req = "R9";
    aux_pin = 1'b0;
    tick(3);
    chk("R8 aux edge sets", rd_data[5], 1);
    chk("R9 no irq with aux_en clear", irq, 0);
    aux_pin = 1'b1;
    wr(8'h03);
    chk("R9 irq with aux_en set", irq, 1);

    cur_req = "R8";
    fetch();
    chk("R6 vec never clears aux", rd_data[5], 1);
    wr(8'h07);
    chk("R8 main ack leaves aux", rd_data[5], 1);
    wr(8'h0b);
    chk("R8 aux ack clears", rd_data[5], 0);
    chk("R8 irq low", irq, 0);

    cur_req = "R10";
    level_mode = 1'b1;
    main_pins[4] = 1'b0;
    tick(3);
    chk("R10 level sets", rd_data[4], 1);
    wr(8'h07);
    chk("R10 ack no lasting effect", rd_data[4], 1);
    main_pins[4] = 1'b1;
    tick(3);
    wr(8'h07);
    chk("R10 ack after release", rd_data[4], 0);
    level_mode = 1'b0;
    tick(1);

    cur_req = "R3";
    main_pins[1] = 1'b0;
    tick(3);
    chk("R3 port pin edge sets", rd_data[4], 1);
    wr(8'h07);
    tick(3);
    chk("R3 held low no re-set", rd_data[4], 0);
    main_pins[1] = 1'b1;
    tick(3);

    cur_req = "R11";
    main_pins[2] = 1'b0;
    tick(2);
    wr(8'h07);
    chk("R11 set wins over ack", rd_data[4], 1);
    main_pins[2] = 1'b1;
    tick(3);
    wr(8'h07);
    chk("R11 later ack clears", rd_data[4], 0);

    cur_req = "R12";
    wr(8'h02);
    wr_data = 8'hfd;
    tick(3);
    chk("R12 enables hold without write", rd_data[1:0], 2'b10);
    chk("R12 flags hold without write", rd_data[5:4], 2'b00);
    wr_data = 8'h00;

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule